// File: doc/BRIEF.md
# Serial EEPROM Byte-Write and Burst-Read Master

This block is a two-wire bus master for a small serial EEPROM with a 9-bit word address. The caller makes a request through a valid/ready handshake. The request gives the operation, a 9-bit start address, a byte count and one byte of write data.

A write stores that single byte. The block then keeps the bus quiet and holds ready low for a programmable write-cycle guard, so that the memory can commit the byte. A read first sends a dummy write to set the address pointer. It then restarts the bus in read direction and streams the requested number of consecutive bytes back to the caller. Each byte is marked by a one-cycle valid strobe.

On the bus side the block produces SCL and drives SDA open-drain through two signals: an active-high pull-low enable and the sampled line level. Bit timing comes from parameters for the system clock rate and the bus rate. If the memory fails to acknowledge an address or data byte, the transfer is abandoned with a STOP and an error pulse.

Top module: `eep_seq_master`

## Requirements
- R1: After reset, req_ready is 1, scl is 1, sda_oe is 0, and rd_valid, done and error are 0.
- R2: One SCL period lasts SLOT = CLK_HZ / SCL_HZ system cycles. Inside each bit slot SCL is low for the first SLOT/2 cycles and high for the last SLOT/2 cycles.
- R3: The first byte after each START is the device byte {6'b101000, address bit 8, direction}. The direction bit is 0 for a write and 1 for a read. The word-address byte carries address bits 7:0. Every byte is shifted MSB first.
- R4: A write sends START, the device byte with direction 0, the word address, the data byte and STOP. The memory then holds the data byte at that address.
- R5: After a successful write, req_ready stays 0 for exactly GUARD_CYC cycles, counted from the cycle in which done is 1. During that time SCL stays high and SDA stays released.
- R6: SDA changes only while SCL is low, except for START (SDA falls during SCL high) and STOP (SDA rises during SCL high). Read bits are sampled at 3/4 of the slot.
- R7: A read sends START, the device byte with direction 0, the word address, a repeated START, the device byte with direction 1, and then receives req_len bytes from consecutive addresses. A req_len of 0 is taken as 1.
- R8: During a read the master acknowledges every received byte except the last, answers the last with a NAK, and then issues STOP. SDA is released during each slave-ACK bit and each received data bit.
- R9: rd_valid is a one-cycle pulse with rd_data for each received byte. done pulses for one cycle after the final STOP of a successful transfer. After a read, req_ready is 1 in that same cycle.
- R10: If any address or data byte gets a NAK, the block issues STOP, pulses error for one cycle instead of done, skips the write guard and returns to ready.
- R11: A request raised while req_ready is 0 is ignored and produces no bus transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Idle and able to accept a request |
| req_write | input | 1 | 1 = byte write, 0 = burst read |
| req_addr | input | 9 | Start word address |
| req_len | input | LEN_W | Number of bytes to read (0 counts as 1) |
| req_wdata | input | 8 | Byte to write |
| rd_valid | output | 1 | Received byte strobe |
| rd_data | output | 8 | Received byte |
| done | output | 1 | Transfer finished without NAK |
| error | output | 1 | Transfer aborted after a NAK |
| scl | output | 1 | Bus clock |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
Each received byte is due one cycle after the last system cycle of its eighth bit slot. done and error are due one cycle after the last cycle of the STOP slot. After a write, ready returns exactly GUARD_CYC cycles after the done cycle.

The bench samples every output on the falling clock edge. A scoreboard pops expected bytes only when rd_valid is seen, so its order check does not depend on absolute timing. The guard length and the SCL period and high time are measured by counting sampled cycles between edges and are compared with the exact values. A bus-level memory model records device bytes, address bytes, STARTs, STOPs and master ACK/NAK counts for each transfer.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_DEVW,
        ST_WADDR,
        ST_WDATA,
        ST_RSTART,
        ST_DEVR,
        ST_RDATA,
        ST_STOP,
        ST_GUARD
    } step_e;

    typedef struct packed {
        logic       wr;
        logic [8:0] addr;
        logic [7:0] wdata;
    } job_t;

    localparam logic [5:0] DEV_PREFIX = 6'b101000;
    localparam logic [3:0] ACK_BIT    = 4'd8;
    localparam logic [3:0] LAST_DBIT  = 4'd7;

    function automatic logic [7:0] dev_byte(input logic a8, input logic rd);
        return {DEV_PREFIX, a8, rd};
    endfunction

    function automatic logic is_tx(input step_e s);
        return (s == ST_DEVW) || (s == ST_WADDR) || (s == ST_WDATA) || (s == ST_DEVR);
    endfunction

    function automatic logic in_slot(input step_e s);
        return (s != ST_IDLE) && (s != ST_GUARD);
    endfunction

endpackage

// File: rtl/eep_slot_timer.sv
module eep_slot_timer #(
    parameter int SLOT = 500
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic t_q1,
    output logic t_half,
    output logic t_q3,
    output logic t_last
);
    localparam int CW = (SLOT > 1) ? $clog2(SLOT) : 1;
    localparam logic [CW-1:0] P_Q1   = CW'(SLOT / 4 - 1);
    localparam logic [CW-1:0] P_HALF = CW'(SLOT / 2 - 1);
    localparam logic [CW-1:0] P_Q3   = CW'((SLOT * 3) / 4 - 1);
    localparam logic [CW-1:0] P_LAST = CW'(SLOT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == P_LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign t_q1   = run && (cnt == P_Q1);
    assign t_half = run && (cnt == P_HALF);
    assign t_q3   = run && (cnt == P_Q3);
    assign t_last = run && (cnt == P_LAST);

    // R2: inside a running slot the phase advances by one each cycle
    a_r2_phase_step: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && cnt != '0) |-> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/eep_guard.sv
module eep_guard #(
    parameter int GUARD_CYC = 250_000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic expired
);
    localparam int GW = $clog2(GUARD_CYC + 1);
    localparam logic [GW-1:0] G_END = GW'(GUARD_CYC - 1);

    logic [GW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (cnt != G_END)
            cnt <= cnt + 1'b1;
    end

    assign expired = en && (cnt == G_END);

    // R5: the guard count never jumps while enabled
    a_r5_guard_step: assert property (@(posedge clk) disable iff (rst)
        (en && $past(en) && cnt != '0) |-> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/eep_seq_master.sv
module eep_seq_master
    import eep_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int SCL_HZ    = 100_000,
    parameter int GUARD_CYC = 250_000,
    parameter int LEN_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [8:0]       req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       req_wdata,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic             error,
    output logic             scl,
    output logic             sda_oe,
    input  logic             sda_in
);
    localparam int SLOT = CLK_HZ / SCL_HZ;
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    step_e            step;
    job_t             job;
    logic [3:0]       bitn;
    logic [7:0]       shreg;
    logic [LEN_W-1:0] remain;
    logic             scl_q, oe_q, nak_q, abort_q;
    logic             rd_valid_q, done_q, err_q;
    logic [7:0]       rd_data_q;
    logic             t_q1, t_half, t_q3, t_last;
    logic             guard_exp;

    eep_slot_timer #(.SLOT(SLOT)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (in_slot(step)),
        .t_q1   (t_q1),
        .t_half (t_half),
        .t_q3   (t_q3),
        .t_last (t_last)
    );

    eep_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk     (clk),
        .rst     (rst),
        .en      (step == ST_GUARD),
        .expired (guard_exp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            step       <= ST_IDLE;
            job        <= '0;
            bitn       <= '0;
            shreg      <= '0;
            remain     <= '0;
            scl_q      <= 1'b1;
            oe_q       <= 1'b0;
            nak_q      <= 1'b0;
            abort_q    <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            case (step)
                ST_IDLE: begin
                    if (req_valid) begin
                        job.wr    <= req_write;
                        job.addr  <= req_addr;
                        job.wdata <= req_wdata;
                        remain    <= (req_len == '0) ? ONE : req_len;
                        abort_q   <= 1'b0;
                        nak_q     <= 1'b0;
                        step      <= ST_START;
                    end
                end
                ST_GUARD: begin
                    if (guard_exp)
                        step <= ST_IDLE;
                end
                default: begin
                    // quarter point: SCL is low, SDA may move
                    if (t_q1) begin
                        case (step)
                            ST_START, ST_RSTART: oe_q <= 1'b0;
                            ST_STOP:             oe_q <= 1'b1;
                            ST_RDATA:            oe_q <= (bitn == ACK_BIT) ? (remain != ONE) : 1'b0;
                            default:             oe_q <= (bitn == ACK_BIT) ? 1'b0 : ~shreg[7];
                        endcase
                    end
                    if (t_half)
                        scl_q <= 1'b1;
                    // three-quarter point: SCL is high, sample or mark START/STOP
                    if (t_q3) begin
                        case (step)
                            ST_START, ST_RSTART: oe_q <= 1'b1;
                            ST_STOP:             oe_q <= 1'b0;
                            ST_RDATA: begin
                                if (bitn != ACK_BIT)
                                    shreg <= {shreg[6:0], sda_in};
                            end
                            default: begin
                                if (bitn == ACK_BIT)
                                    nak_q <= sda_in;
                                else
                                    shreg <= {shreg[6:0], 1'b0};
                            end
                        endcase
                    end
                    if (t_last) begin
                        if (step != ST_STOP)
                            scl_q <= 1'b0;
                        case (step)
                            ST_START: begin
                                step  <= ST_DEVW;
                                bitn  <= '0;
                                shreg <= dev_byte(job.addr[8], 1'b0);
                            end
                            ST_RSTART: begin
                                step  <= ST_DEVR;
                                bitn  <= '0;
                                shreg <= dev_byte(job.addr[8], 1'b1);
                            end
                            ST_STOP: begin
                                if (abort_q) begin
                                    err_q <= 1'b1;
                                    step  <= ST_IDLE;
                                end else begin
                                    done_q <= 1'b1;
                                    step   <= job.wr ? ST_GUARD : ST_IDLE;
                                end
                            end
                            default: begin
                                if (bitn != ACK_BIT) begin
                                    bitn <= bitn + 1'b1;
                                    if (step == ST_RDATA && bitn == LAST_DBIT) begin
                                        rd_valid_q <= 1'b1;
                                        rd_data_q  <= shreg;
                                    end
                                end else begin
                                    bitn <= '0;
                                    if (is_tx(step) && nak_q) begin
                                        abort_q <= 1'b1;
                                        step    <= ST_STOP;
                                    end else begin
                                        case (step)
                                            ST_DEVW: begin
                                                step  <= ST_WADDR;
                                                shreg <= job.addr[7:0];
                                            end
                                            ST_WADDR: begin
                                                if (job.wr) begin
                                                    step  <= ST_WDATA;
                                                    shreg <= job.wdata;
                                                end else begin
                                                    step <= ST_RSTART;
                                                end
                                            end
                                            ST_DEVR: step <= ST_RDATA;
                                            ST_RDATA: begin
                                                if (remain == ONE)
                                                    step <= ST_STOP;
                                                else
                                                    remain <= remain - 1'b1;
                                            end
                                            default: step <= ST_STOP;
                                        endcase
                                    end
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    assign req_ready = (step == ST_IDLE);
    assign rd_valid  = rd_valid_q;
    assign rd_data   = rd_data_q;
    assign done      = done_q;
    assign error     = err_q;
    assign scl       = scl_q;
    assign sda_oe    = oe_q;

    // R6: with SCL held high, SDA moves only for START or STOP
    a_r6_sda_moves_low: assert property (@(posedge clk) disable iff (rst)
        (scl_q && $past(scl_q) && (oe_q != $past(oe_q)))
            |-> ($past(step) == ST_START || $past(step) == ST_RSTART || $past(step) == ST_STOP));

    // R8: SDA released while the slave owns the line
    a_r8_release_slave_bits: assert property (@(posedge clk) disable iff (rst)
        (t_q3 && ((is_tx(step) && bitn == ACK_BIT) || (step == ST_RDATA && bitn != ACK_BIT)))
            |-> !oe_q);

    // R9: each byte strobe lasts one cycle
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid_q |=> !rd_valid_q);

    // R10: a transfer ends either done or error, never both
    a_r10_done_xor_error: assert property (@(posedge clk) disable iff (rst)
        !(done_q && err_q));

    // R5: bus idles during the write guard
    a_r5_guard_bus_idle: assert property (@(posedge clk) disable iff (rst)
        (step == ST_GUARD) |-> (scl_q && !oe_q));

endmodule

// File: tb/sim_eep_seq_master.sv
module sim_eep_seq_master;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 4_000_000;
    localparam int SCL_HZ     = 100_000;
    localparam int SLOT       = CLK_HZ / SCL_HZ;
    localparam int GUARD      = 600;
    localparam int LEN_W      = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [8:0]       req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [7:0]       req_wdata = '0;
    logic             req_ready, rd_valid, done, error, scl, m_oe;
    logic [7:0]       rd_data;
    logic             s_oe;
    logic             nak_mode = 1'b0;
    wire              sda_w = !(m_oe || s_oe);

    always #(CLK_PERIOD / 2) clk = ~clk;

    eep_seq_master #(
        .CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .GUARD_CYC(GUARD), .LEN_W(LEN_W)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .error(error), .scl(scl), .sda_oe(m_oe), .sda_in(sda_w)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    // ---------------- bus memory model ----------------
    logic [7:0] smem [512];
    logic       ps, pd, sin, srd, spend, ahi;
    int         sbit, sbyte;
    logic [7:0] ssh;
    logic [8:0] sptr;
    logic [7:0] dev_w_log, dev_r_log, waddr_log;
    int         starts, stops, macks, mnaks;

    always @(posedge clk) begin
        if (rst) begin
            ps <= 1'b1; pd <= 1'b1; s_oe <= 1'b0; sin <= 1'b0; srd <= 1'b0;
            spend <= 1'b0; ahi <= 1'b0; sbit <= 0; sbyte <= 0; ssh <= '0; sptr <= '0;
            dev_w_log <= '0; dev_r_log <= '0; waddr_log <= '0;
            starts <= 0; stops <= 0; macks <= 0; mnaks <= 0;
            for (int i = 0; i < 512; i++) smem[i] <= pat(i);
        end else begin
            ps <= scl;
            pd <= sda_w;
            if (ps && scl && pd && !sda_w) begin
                sin <= 1'b1; sbit <= 0; sbyte <= 0; srd <= 1'b0; spend <= 1'b0;
                s_oe <= 1'b0; starts <= starts + 1;
            end else if (ps && scl && !pd && sda_w) begin
                sin <= 1'b0; srd <= 1'b0; spend <= 1'b0; s_oe <= 1'b0;
                stops <= stops + 1;
            end else if (sin && !ps && scl) begin
                if (sbit == 8) begin
                    sbit <= 0;
                    if (srd) begin
                        if (sda_w) begin mnaks <= mnaks + 1; srd <= 1'b0; end
                        else macks <= macks + 1;
                    end else if (spend) begin
                        srd <= 1'b1; spend <= 1'b0;
                    end
                end else begin
                    sbit <= sbit + 1;
                    if (!srd) ssh <= {ssh[6:0], sda_w};
                end
            end else if (sin && ps && !scl) begin
                if (srd) begin
                    if (sbit == 8) begin s_oe <= 1'b0; sptr <= sptr + 1'b1; end
                    else s_oe <= !smem[sptr][7 - sbit];
                end else if (sbit == 8) begin
                    sbyte <= sbyte + 1;
                    if (nak_mode) s_oe <= 1'b0;
                    else if (sbyte == 0) begin
                        if (ssh[7:2] == 6'b101000) begin
                            s_oe <= 1'b1;
                            if (ssh[0]) begin spend <= 1'b1; dev_r_log <= ssh; end
                            else begin ahi <= ssh[1]; dev_w_log <= ssh; end
                        end else s_oe <= 1'b0;
                    end else if (sbyte == 1) begin
                        sptr <= {ahi, ssh}; waddr_log <= ssh; s_oe <= 1'b1;
                    end else begin
                        smem[sptr] <= ssh; sptr <= sptr + 1'b1; s_oe <= 1'b1;
                    end
                end else s_oe <= 1'b0;
            end
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] mirror [512];
    logic [7:0] expq [$];

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: scoreboard pops, pulse counters, timing measurements
    int   cyc = 0, last_rise = 0, per = 0, hi = 0;
    int   done_cnt = 0, err_cnt = 0, guard_len = -1, gcount = 0;
    int   ready_at_err = 0;
    logic gmeas = 1'b0, scl_prev = 1'b1;
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (scl && !scl_prev) begin per = cyc - last_rise; last_rise = cyc; end
            if (!scl && scl_prev) hi = cyc - last_rise;
            scl_prev = scl;
            if (rd_valid) begin
                if (expq.size() == 0) check("R9 unexpected byte", int'(rd_data), -1);
                else check("R7 scoreboard byte", int'(rd_data), int'(expq.pop_front()));
            end
            if (done) begin done_cnt++; gmeas = 1'b1; gcount = 0; end
            if (error) begin err_cnt++; ready_at_err = int'(req_ready); end
            if (gmeas) begin
                if (!req_ready) gcount++;
                else begin gmeas = 1'b0; guard_len = gcount; end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic issue(input logic wr, input logic [8:0] a, input logic [7:0] d, input int len);
        int n;
        while (!req_ready) tick();
        req_write = wr; req_addr = a; req_wdata = d; req_len = LEN_W'(len);
        req_valid = 1'b1;
        tick();
        req_valid = 1'b0;
        if (!nak_mode) begin
            if (wr) mirror[a] = d;
            else begin
                n = (len == 0) ? 1 : len;
                for (int i = 0; i < n; i++) expq.push_back(mirror[(int'(a) + i) % 512]);
            end
        end
    endtask

    task automatic wait_end();
        int d0 = done_cnt;
        int e0 = err_cnt;
        int t = 0;
        while (done_cnt == d0 && err_cnt == e0 && t < 20000) begin tick(); t++; end
    endtask

    task automatic wait_ready();
        while (!req_ready) tick();
        tick();
    endtask

    int s0, p0, a0, k0, d0, e0;
    task automatic snap();
        s0 = starts; p0 = stops; a0 = macks; k0 = mnaks; d0 = done_cnt; e0 = err_cnt;
    endtask

    task automatic do_read(input logic [8:0] a, input int len, input string tag);
        int n = (len == 0) ? 1 : len;
        snap();
        issue(1'b0, a, 8'h00, len);
        wait_end();
        wait_ready();
        check({tag, " R7 two STARTs"}, starts - s0, 2);
        check({tag, " R8 one STOP"}, stops - p0, 1);
        check({tag, " R8 master ACKs"}, macks - a0, n - 1);
        check({tag, " R8 master NAK"}, mnaks - k0, 1);
        check({tag, " R3 dev byte write dir"}, int'(dev_w_log), int'({6'b101000, a[8], 1'b0}));
        check({tag, " R3 dev byte read dir"}, int'(dev_r_log), int'({6'b101000, a[8], 1'b1}));
        check({tag, " R3 word address"}, int'(waddr_log), int'(a[7:0]));
        check({tag, " R9 done pulse"}, done_cnt - d0, 1);
        check({tag, " R9 ready with done"}, guard_len, 0);
        check({tag, " R7 all bytes"}, expq.size(), 0);
    endtask

    task automatic do_write(input logic [8:0] a, input logic [7:0] d, input string tag);
        snap();
        issue(1'b1, a, d, 1);
        wait_end();
        wait_ready();
        check({tag, " R4 one START"}, starts - s0, 1);
        check({tag, " R4 one STOP"}, stops - p0, 1);
        check({tag, " R3 dev byte"}, int'(dev_w_log), int'({6'b101000, a[8], 1'b0}));
        check({tag, " R3 word address"}, int'(waddr_log), int'(a[7:0]));
        check({tag, " R4 memory content"}, int'(smem[a]), int'(d));
        check({tag, " R5 guard length"}, guard_len, GUARD);
        check({tag, " R2 SCL period"}, per, SLOT);
        check({tag, " R2 SCL high time"}, hi, SLOT / 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) mirror[i] = pat(i);
        repeat (4) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        check("R1 ready", int'(req_ready), 1);
        check("R1 scl", int'(scl), 1);
        check("R1 sda_oe", int'(m_oe), 0);
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 done", int'(done), 0);
        check("R1 error", int'(error), 0);

        do_write(9'h003, 8'h55, "wr low");
        do_write(9'h1F0, 8'hA7, "wr high");

        do_read(9'h003, 1, "rd single");
        do_read(9'h1EE, 4, "rd across");
        do_read(9'h010, 0, "rd zero len");
        do_read(9'h1FE, 4, "rd wrap");
        do_read(9'h080, 7, "rd long");

        // R11: a write request raised while busy is ignored
        snap();
        issue(1'b0, 9'h003, 8'h00, 2);
        req_write = 1'b1; req_addr = 9'h003; req_wdata = 8'hEE; req_valid = 1'b1;
        repeat (5) tick();
        req_valid = 1'b0;
        wait_end();
        wait_ready();
        repeat (20) tick();
        check("R11 only one transfer", starts - s0, 2);
        check("R11 memory untouched", int'(smem[3]), 8'h55);
        check("R11 scoreboard drained", expq.size(), 0);
        do_read(9'h003, 1, "rd after ignore");

        // R10: slave NAK aborts
        nak_mode = 1'b1;
        snap();
        issue(1'b1, 9'h020, 8'h3C, 1);
        wait_end();
        check("R10 error pulse", err_cnt - e0, 1);
        check("R10 no done", done_cnt - d0, 0);
        check("R10 ready without guard", ready_at_err, 1);
        tick();
        check("R10 STOP issued", stops - p0, 1);
        check("R10 memory unchanged", int'(smem[9'h020]), int'(pat(9'h020)));
        snap();
        issue(1'b0, 9'h040, 8'h00, 3);
        wait_end();
        tick();
        check("R10 read error pulse", err_cnt - e0, 1);
        check("R10 read no bytes", expq.size(), 0);
        nak_mode = 1'b0;
        do_read(9'h020, 2, "rd after nak");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule